// File: doc/BRIEF.md
# Packet Instruction Buffer for the Fetch Stage

This block is a small, fully associative instruction store in the fetch stage. It holds instruction packets. A packet is a run of instruction words whose last word carries an end marker. No program counter exists. The block keeps an issue pointer that indexes a storage slot. Once a packet has been entered, the pointer walks forward one slot per issued word and stops after the marked last word.

A packet can be entered in two ways. The first is a fetch request, which names the packet by its memory address. That address is compared against the start tags of all resident packets at once. On a hit, the pointer moves to the packet's first slot. On a miss, the block requests the packet from the next memory level. The returning words are written into slots starting at a circular write pointer, and any older packet they overwrite is invalidated. Issue may begin as soon as the first word lands. The second way is an in-buffer jump, which names a slot directly and skips the tag comparison. Packets longer than the store are streamed through: the fill may overwrite only slots that have already been issued.

Top module: `l0_pkt_ibuf`

## Requirements
- R1: After reset, `issue_valid`, `fetch_hit`, `miss_req` and `fill_ready` are 0, `cmd_ready` is 1, and no address is resident, so the first fetch misses.
- R2: A fetch to a non-resident address raises `miss_req` for exactly one cycle, in the cycle after the request, with `miss_addr` equal to the requested address. The packet is stored starting at the slot after the last word of the previous fill, which is slot 0 after reset, and the index wraps modulo DEPTH.
- R3: During a fill, a word can issue from the cycle after it is written. When issue has caught up with the fill, `issue_valid` stays 0 until the next word arrives.
- R4: Within a packet, words issue in slot order, and `issue_slot` increments by one per issued word. After the word flagged by `issue_eop` has been accepted, `issue_valid` is 0.
- R5: A fetch to a resident address raises `fetch_hit` in the cycle after the request, with `fetch_slot` equal to the packet's first slot. In that same cycle, `issue_valid` is 1 and `issue_instr` holds the first word. `miss_req` stays 0.
- R6: An accepted jump sets `issue_slot` to `jump_slot` in the next cycle and issues from there to the next end marker. It raises neither `fetch_hit` nor `miss_req`.
- R7: `cmd_ready` is 0 from the cycle after a miss until the packet's end word has issued. While `cmd_ready` is 0, fetch and jump requests are ignored: no hit, no miss and no pointer change.
- R8: A packet is no longer found by fetch once any of its slots has been overwritten by a later fill. A later fetch of its address misses and refills it.
- R9: A fill holds at most DEPTH words that have not yet issued. When that limit is reached, `fill_ready` is 0. A packet longer than DEPTH still issues completely and in order, with slots wrapping.
- R10: When a jump and a fetch are requested in the same cycle, the jump is taken and the fetch is dropped.
- R11: While `issue_ready` is 0 and no command is accepted, a valid issued word stays valid, and `issue_instr` and `issue_slot` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Request to enter the packet at `fetch_addr` |
| fetch_addr | input | AW | Memory address of the requested packet |
| jump_req | input | 1 | Request to move the issue pointer without a tag check |
| jump_slot | input | log2(DEPTH) | Target slot of the jump |
| cmd_ready | output | 1 | Fetch and jump requests are accepted |
| fetch_hit | output | 1 | One-cycle pulse: the last fetch hit |
| fetch_slot | output | log2(DEPTH) | First slot of the packet that hit |
| miss_req | output | 1 | One-cycle pulse: fetch the packet at `miss_addr` |
| miss_addr | output | AW | Address of the missed packet |
| fill_valid | input | 1 | A fill word is presented |
| fill_data | input | IW | Fill instruction word |
| fill_eop | input | 1 | The fill word ends its packet |
| fill_ready | output | 1 | The fill word is accepted at this edge |
| issue_valid | output | 1 | An instruction is presented to decode |
| issue_ready | input | 1 | Decode accepts the instruction |
| issue_instr | output | IW | Instruction word |
| issue_eop | output | 1 | The instruction ends its packet |
| issue_slot | output | log2(DEPTH) | Slot index of the presented instruction |

## Verification
Issue is tried against fills that arrive with gaps, which separates correct stalling from issuing stale slot contents. It is also tried against back-to-back fills and against fills held back by a stalled decode, which shows that the write pointer and the unissued-word count agree. Hits, jumps and simultaneous jump-plus-fetch requests run on resident packets, which separates the tag path, the direct-slot path and their priority. A packet of DEPTH+6 words wraps the store and overwrites every older packet, including its own first slot. Fetches issued afterwards then tell correct invalidation apart from stale hits.

// File: rtl/l0ib_pkg.sv
package l0ib_pkg;

   // Outcome of the command arbitration in one cycle
   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_JUMP = 2'd1,
      CMD_HIT  = 2'd2,
      CMD_MISS = 2'd3
   } l0ib_cmd_e;

endpackage

// File: rtl/l0ib_tag_cam.sv
module l0ib_tag_cam #(
   parameter int DEPTH = 64,
   parameter int AW    = 30,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] lk_addr,
   output logic          lk_hit,
   output logic [PW-1:0] lk_idx,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_idx,
   input  logic [AW-1:0] wr_addr,
   input  logic          kill_en,
   input  logic [PW-1:0] kill_idx
);

   logic [AW-1:0]    tag_q [DEPTH];
   logic [DEPTH-1:0] tv_q;
   logic [DEPTH-1:0] match;

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      // a new start tag wins over a kill aimed at the same entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tv_q[i] <= 1'b0;
         end else if (wr_en && (wr_idx == PW'(i))) begin
            tv_q[i] <= 1'b1;
         end else if (kill_en && (kill_idx == PW'(i))) begin
            tv_q[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PW'(i))) begin
            tag_q[i] <= wr_addr;
         end
      end

      assign match[i] = tv_q[i] && (tag_q[i] == lk_addr);
   end

   always_comb begin
      lk_idx = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (match[k]) begin
            lk_idx = lk_idx | PW'(k);
         end
      end
   end

   assign lk_hit = |match;

   // R8: invalidation on overwrite keeps every address resident at most once
   p_onehot_match_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

endmodule

// File: rtl/l0ib_slot_store.sv
module l0ib_slot_store #(
   parameter int DEPTH = 64,
   parameter int IW    = 32,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_idx,
   input  logic [IW-1:0] wr_data,
   input  logic          wr_eop,
   input  logic [PW-1:0] wr_owner,
   input  logic [PW-1:0] rd_idx,
   output logic [IW-1:0] rd_data,
   output logic          rd_eop,
   output logic          rd_vld,
   output logic          old_vld,
   output logic [PW-1:0] old_owner
);

   logic [IW-1:0]    word_q  [DEPTH];
   logic [PW-1:0]    owner_q [DEPTH];
   logic [DEPTH-1:0] eop_q;
   logic [DEPTH-1:0] vld_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
         end else if (wr_en && (wr_idx == PW'(i))) begin
            vld_q[i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PW'(i))) begin
            word_q[i]  <= wr_data;
            eop_q[i]   <= wr_eop;
            owner_q[i] <= wr_owner;
         end
      end
   end

   assign rd_data   = word_q[rd_idx];
   assign rd_eop    = eop_q[rd_idx];
   assign rd_vld    = vld_q[rd_idx];
   assign old_vld   = vld_q[wr_idx];
   assign old_owner = owner_q[wr_idx];

endmodule

// File: rtl/l0_pkt_ibuf.sv
module l0_pkt_ibuf
   import l0ib_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IW    = 32,
   parameter int AW    = 30,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_req,
   input  logic [AW-1:0] fetch_addr,
   input  logic          jump_req,
   input  logic [PW-1:0] jump_slot,
   output logic          cmd_ready,
   output logic          fetch_hit,
   output logic [PW-1:0] fetch_slot,
   output logic          miss_req,
   output logic [AW-1:0] miss_addr,
   input  logic          fill_valid,
   input  logic [IW-1:0] fill_data,
   input  logic          fill_eop,
   output logic          fill_ready,
   output logic          issue_valid,
   input  logic          issue_ready,
   output logic [IW-1:0] issue_instr,
   output logic          issue_eop,
   output logic [PW-1:0] issue_slot
);

   localparam int CW = PW + 1;
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("l0_pkt_ibuf: DEPTH must be a power of two, at least 2");
   end
   if (IW < 1 || AW < 1) begin : g_bad_width
      $error("l0_pkt_ibuf: IW and AW must be positive");
   end

   // issue state
   logic          active_q, stream_q;
   logic [PW-1:0] rd_ptr_q;
   logic [CW-1:0] ahead_q, ahead_nxt;
   // fill state
   logic          filling_q, first_q;
   logic [PW-1:0] wptr_q, head_q;
   logic [AW-1:0] maddr_q;
   // command results
   logic          hit_q, miss_q;
   logic [PW-1:0] hslot_q;

   l0ib_cmd_e     cmd;
   logic          lk_hit;
   logic [PW-1:0] lk_idx;
   logic          fill_fire, issue_fire;
   logic [IW-1:0] rd_data;
   logic          rd_eop, rd_vld, old_vld;
   logic [PW-1:0] old_owner, wr_owner;

   assign cmd_ready = !stream_q;

   always_comb begin
      cmd = CMD_IDLE;
      if (cmd_ready) begin
         if (jump_req) begin
            cmd = CMD_JUMP;
         end else if (fetch_req) begin
            cmd = lk_hit ? CMD_HIT : CMD_MISS;
         end
      end
   end

   assign fill_ready  = filling_q && (ahead_q != FULL);
   assign fill_fire   = fill_valid && fill_ready;
   assign issue_valid = active_q && (stream_q ? (ahead_q != '0) : rd_vld);
   assign issue_fire  = issue_valid && issue_ready;
   assign wr_owner    = first_q ? wptr_q : head_q;

   always_comb begin
      ahead_nxt = ahead_q;
      if (fill_fire)  ahead_nxt = ahead_nxt + CW'(1);
      if (issue_fire) ahead_nxt = ahead_nxt - CW'(1);
   end

   l0ib_tag_cam #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_addr  (fetch_addr),
      .lk_hit   (lk_hit),
      .lk_idx   (lk_idx),
      .wr_en    (fill_fire && first_q),
      .wr_idx   (wptr_q),
      .wr_addr  (maddr_q),
      .kill_en  (fill_fire && old_vld),
      .kill_idx (old_owner)
   );

   l0ib_slot_store #(.DEPTH(DEPTH), .IW(IW), .PW(PW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (fill_fire),
      .wr_idx    (wptr_q),
      .wr_data   (fill_data),
      .wr_eop    (fill_eop),
      .wr_owner  (wr_owner),
      .rd_idx    (rd_ptr_q),
      .rd_data   (rd_data),
      .rd_eop    (rd_eop),
      .rd_vld    (rd_vld),
      .old_vld   (old_vld),
      .old_owner (old_owner)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         stream_q  <= 1'b0;
         rd_ptr_q  <= '0;
         ahead_q   <= '0;
         filling_q <= 1'b0;
         first_q   <= 1'b0;
         wptr_q    <= '0;
         head_q    <= '0;
         maddr_q   <= '0;
         hit_q     <= 1'b0;
         miss_q    <= 1'b0;
         hslot_q   <= '0;
      end else begin
         hit_q  <= 1'b0;
         miss_q <= 1'b0;

         if (issue_fire) begin
            if (issue_eop) begin
               active_q <= 1'b0;
               stream_q <= 1'b0;
            end else begin
               rd_ptr_q <= rd_ptr_q + PW'(1);
            end
         end
         if (stream_q) begin
            ahead_q <= ahead_nxt;
         end

         if (fill_fire) begin
            wptr_q  <= wptr_q + PW'(1);
            first_q <= 1'b0;
            if (first_q)  head_q    <= wptr_q;
            if (fill_eop) filling_q <= 1'b0;
         end

         // an accepted command overrides the pointer update above
         unique case (cmd)
            CMD_JUMP: begin
               active_q <= 1'b1;
               rd_ptr_q <= jump_slot;
            end
            CMD_HIT: begin
               active_q <= 1'b1;
               rd_ptr_q <= lk_idx;
               hit_q    <= 1'b1;
               hslot_q  <= lk_idx;
            end
            CMD_MISS: begin
               active_q  <= 1'b1;
               stream_q  <= 1'b1;
               rd_ptr_q  <= wptr_q;
               ahead_q   <= '0;
               filling_q <= 1'b1;
               first_q   <= 1'b1;
               maddr_q   <= fetch_addr;
               miss_q    <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign fetch_hit   = hit_q;
   assign fetch_slot  = hslot_q;
   assign miss_req    = miss_q;
   assign miss_addr   = maddr_q;
   assign issue_instr = rd_data;
   assign issue_eop   = rd_eop;
   assign issue_slot  = rd_ptr_q;

   // R2: the refill request is a single-cycle pulse
   p_miss_pulse_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      miss_req |=> !miss_req);

   // R5: a hit presents the packet's first slot at once
   p_hit_issues_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hit |-> (issue_valid && issue_slot == fetch_slot));

   // R7: no hit can follow a cycle in which commands were blocked
   p_blocked_no_hit_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |=> !fetch_hit);

   // R4: accepting the end word leaves nothing to issue
   p_eop_stops_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready && issue_eop && !jump_req && !fetch_req)
      |=> !issue_valid);

   // R9: never more unissued words than slots
   p_ahead_bound_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ahead_q <= FULL);

   // R11: a stalled word is held
   p_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready && !jump_req && !fetch_req)
      |=> (issue_valid && $stable(issue_instr) && $stable(issue_slot)));

endmodule

// File: tb/l0_pkt_ibuf_tb.sv
module l0_pkt_ibuf_tb;

   localparam int DEPTH = 64;
   localparam int IW    = 32;
   localparam int AW    = 30;
   localparam int PW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_req = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          jump_req = 1'b0;
   logic [PW-1:0] jump_slot = '0;
   logic          cmd_ready, fetch_hit, miss_req, fill_ready;
   logic [PW-1:0] fetch_slot, issue_slot;
   logic [AW-1:0] miss_addr;
   logic          fill_valid = 1'b0;
   logic [IW-1:0] fill_data = '0;
   logic          fill_eop = 1'b0;
   logic          issue_valid, issue_eop;
   logic          issue_ready = 1'b1;
   logic [IW-1:0] issue_instr;

   always #2.5 clk = ~clk;

   l0_pkt_ibuf #(.DEPTH(DEPTH), .IW(IW), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .jump_req(jump_req), .jump_slot(jump_slot),
      .cmd_ready(cmd_ready), .fetch_hit(fetch_hit), .fetch_slot(fetch_slot),
      .miss_req(miss_req), .miss_addr(miss_addr),
      .fill_valid(fill_valid), .fill_data(fill_data), .fill_eop(fill_eop),
      .fill_ready(fill_ready),
      .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_instr(issue_instr), .issue_eop(issue_eop), .issue_slot(issue_slot)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // log of issued words, sampled at the falling edge before the accepting edge
   logic [IW-1:0] log_w [128];
   logic [PW-1:0] log_s [128];
   logic          log_e [128];
   int            log_n = 0;

   always @(negedge clk) begin
      if (rst_n && issue_valid && issue_ready && log_n < 128) begin
         log_w[log_n] = issue_instr;
         log_s[log_n] = issue_slot;
         log_e[log_n] = issue_eop;
         log_n = log_n + 1;
      end
   end

   function automatic logic [IW-1:0] wd(int pkt, int i);
      return {8'(pkt), 24'(i)};
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_fetch(logic [AW-1:0] a);
      @(posedge clk); #1;
      fetch_req = 1'b1; fetch_addr = a;
      @(posedge clk); #1;
      fetch_req = 1'b0;
   endtask

   task automatic send_fill(logic [IW-1:0] d, logic e);
      @(posedge clk); #1;
      fill_valid = 1'b1; fill_data = d; fill_eop = e;
      do @(negedge clk); while (!fill_ready);
      @(posedge clk); #1;
      fill_valid = 1'b0;
   endtask

   task automatic wait_eop();
      for (int t = 0; t < 400; t++) begin
         @(negedge clk);
         if (log_n > 0 && log_e[log_n-1]) break;
      end
      @(negedge clk);
   endtask

   task automatic check_log(string req, int pkt, int first, int start_slot, int cnt);
      chk(log_n == cnt, req, log_n, cnt);
      for (int i = 0; i < cnt && i < log_n; i++) begin
         chk(log_w[i] == wd(pkt, first + i), req, log_w[i], wd(pkt, first + i));
         chk(log_s[i] == PW'(start_slot + i), req, log_s[i], PW'(start_slot + i));
         chk(log_e[i] == (i == cnt - 1), req, log_e[i], (i == cnt - 1));
      end
   endtask

   // R1
   task automatic t_reset();
      @(negedge clk);
      chk(!issue_valid, "R1 issue_valid", issue_valid, 0);
      chk(!fetch_hit, "R1 fetch_hit", fetch_hit, 0);
      chk(!miss_req, "R1 miss_req", miss_req, 0);
      chk(!fill_ready, "R1 fill_ready", fill_ready, 0);
      chk(cmd_ready, "R1 cmd_ready", cmd_ready, 1);
   endtask

   // R1 R2 R3 R4 R7: first miss, words arrive with gaps
   task automatic t_miss_gaps();
      log_n = 0;
      do_fetch(30'h40);
      @(negedge clk);
      chk(miss_req, "R2 miss pulse", miss_req, 1);
      chk(miss_addr == 30'h40, "R2 miss addr", miss_addr, 30'h40);
      chk(!fetch_hit, "R1 first fetch misses", fetch_hit, 0);
      chk(!cmd_ready, "R7 busy after miss", cmd_ready, 0);
      chk(!issue_valid, "R3 nothing before fill", issue_valid, 0);
      @(negedge clk);
      chk(!miss_req, "R2 single cycle", miss_req, 1);
      send_fill(wd(1, 0), 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk(!issue_valid, "R3 stall on missing word", issue_valid, 0);
      chk(log_n == 1, "R3 first word issued early", log_n, 1);
      send_fill(wd(1, 1), 1'b0);
      repeat (2) @(posedge clk);
      send_fill(wd(1, 2), 1'b1);
      wait_eop();
      check_log("R4 packet A order", 1, 0, 0, 3);
      chk(!issue_valid, "R4 idle after end", issue_valid, 0);
      chk(cmd_ready, "R7 ready after end", cmd_ready, 1);
   endtask

   // R2: second packet continues at the round-robin pointer
   task automatic t_miss_b2b();
      log_n = 0;
      do_fetch(30'h80);
      for (int i = 0; i < 5; i++) send_fill(wd(2, i), i == 4);
      wait_eop();
      check_log("R2 packet B slots 3..7", 2, 0, 3, 5);
   endtask

   // R5
   task automatic t_hit();
      log_n = 0;
      do_fetch(30'h40);
      @(negedge clk);
      chk(fetch_hit, "R5 hit pulse", fetch_hit, 1);
      chk(fetch_slot == 0, "R5 hit slot", fetch_slot, 0);
      chk(!miss_req, "R5 no miss", miss_req, 0);
      chk(issue_valid && issue_instr == wd(1, 0), "R5 first word", issue_instr, wd(1, 0));
      wait_eop();
      check_log("R5 hit replay", 1, 0, 0, 3);
   endtask

   // R11
   task automatic t_hold();
      log_n = 0;
      issue_ready = 1'b0;
      do_fetch(30'h80);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(issue_valid && issue_instr == wd(2, 0) && issue_slot == 3,
             "R11 held word", issue_instr, wd(2, 0));
      end
      @(posedge clk); #1;
      issue_ready = 1'b1;
      wait_eop();
      check_log("R11 after release", 2, 0, 3, 5);
   endtask

   // R6
   task automatic t_jump();
      log_n = 0;
      @(posedge clk); #1;
      jump_req = 1'b1; jump_slot = PW'(5);
      @(posedge clk); #1;
      jump_req = 1'b0;
      @(negedge clk);
      chk(issue_slot == 5, "R6 jump slot", issue_slot, 5);
      chk(!fetch_hit && !miss_req, "R6 no lookup", {fetch_hit, miss_req}, 0);
      wait_eop();
      check_log("R6 jump tail", 2, 2, 5, 3);
   endtask

   // R10
   task automatic t_jump_vs_fetch();
      log_n = 0;
      @(posedge clk); #1;
      jump_req = 1'b1; jump_slot = PW'(1);
      fetch_req = 1'b1; fetch_addr = 30'h80;
      @(posedge clk); #1;
      jump_req = 1'b0; fetch_req = 1'b0;
      @(negedge clk);
      chk(!fetch_hit && !miss_req, "R10 fetch dropped", {fetch_hit, miss_req}, 0);
      chk(issue_slot == 1, "R10 jump taken", issue_slot, 1);
      wait_eop();
      check_log("R10 jump tail", 1, 1, 1, 2);
   endtask

   // R7: commands ignored during a fill
   task automatic t_blocked();
      log_n = 0;
      do_fetch(30'hC0);
      @(posedge clk); #1;
      jump_req = 1'b1; jump_slot = PW'(0);
      fetch_req = 1'b1; fetch_addr = 30'h40;
      @(posedge clk); #1;
      jump_req = 1'b0; fetch_req = 1'b0;
      @(negedge clk);
      chk(!fetch_hit, "R7 blocked fetch", fetch_hit, 0);
      chk(issue_slot == 8 && !issue_valid, "R7 pointer kept", issue_slot, 8);
      for (int i = 0; i < 2; i++) send_fill(wd(3, i), i == 1);
      wait_eop();
      check_log("R7 packet C", 3, 0, 8, 2);
   endtask

   // R9: packet longer than the store
   task automatic t_long();
      log_n = 0;
      issue_ready = 1'b0;
      do_fetch(30'h200);
      for (int i = 0; i < DEPTH; i++) send_fill(wd(4, i), 1'b0);
      @(negedge clk);
      chk(!fill_ready, "R9 fill blocked when full", fill_ready, 0);
      chk(issue_valid && issue_slot == 10, "R9 head waiting", issue_slot, 10);
      @(posedge clk); #1;
      issue_ready = 1'b1;
      for (int i = DEPTH; i < DEPTH + 6; i++) send_fill(wd(4, i), i == DEPTH + 5);
      wait_eop();
      check_log("R9 long packet", 4, 0, 10, DEPTH + 6);
   endtask

   // R8: overwritten packets miss and refill
   task automatic t_invalidate();
      log_n = 0;
      do_fetch(30'h40);
      @(negedge clk);
      chk(miss_req && !fetch_hit, "R8 A overwritten", miss_req, 1);
      send_fill(wd(5, 0), 1'b1);
      wait_eop();
      check_log("R8 A refill at 16", 5, 0, 16, 1);
      log_n = 0;
      do_fetch(30'h200);
      @(negedge clk);
      chk(miss_req && !fetch_hit, "R8 own head overwritten", miss_req, 1);
      send_fill(wd(6, 0), 1'b1);
      wait_eop();
      log_n = 0;
      do_fetch(30'h40);
      @(negedge clk);
      chk(fetch_hit && fetch_slot == 16, "R8 refilled A hits", fetch_slot, 16);
      wait_eop();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_miss_gaps();
      t_miss_b2b();
      t_hit();
      t_hold();
      t_jump();
      t_jump_vs_fetch();
      t_blocked();
      t_long();
      t_invalidate();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule